// File: doc/BRIEF.md
# Serial Port Control and Status Register Front End

This block is the register front end of a FIFO-based serial port. It sits on a simple single-cycle register bus (address, write data, write strobe, read strobe) and holds three registers: a line mode register, a control register and a status register. The mode and control values are driven out to the baud and shift logic. The status flags are driven to the transmit and receive paths.

Software clears a status flag by writing a zero to its bit. A one leaves the flag unchanged. Hardware sets flags from a break-detected pulse and from the receive-path handshake pulses. While the transmitter is enabled, every read of the status register sets the transmit-empty and transmit-end flags again, so a polling driver always finds the transmitter ready. Clearing the transmit-enable bit through a control write sets the transmit-end flag. The transmit interrupt output follows the interrupt-enable bit of the control register.

Read data is combinational. It is valid in the same cycle as the read strobe, and it is zero whenever no read is requested. Register side effects take hold at the next clock edge.

Top module: `ser_ctrl_regs`

## Requirements
- R1: A write to the mode register (offset 0x00) stores the data ANDed with 0x7B. Bits 7 and 2 of the mode register always read 0. The reset value is 0x00.
- R2: A write to the control register (offset 0x08) stores the data ANDed with 0xFA. The control register resets to 0x20, where bit 5 is transmit enable.
- R3: A control write whose data has bit 5 clear sets the transmit-end flag (status bit 6) at the next edge.
- R4: The output `tx_irq` equals bit 7 of the control register. After a control write it therefore follows bit 7 of the written data. It is 0 after reset.
- R5: The status register (offset 0x10) reads transmit-end in bit 6, transmit-empty in bit 5, break in bit 4, receive-full in bit 1 and data-ready in bit 0. Bits 7, 3 and 2 read 0. The reset value is 0x60.
- R6: A status write clears each of bits 6, 5, 4, 1 and 0 whose written value is 0, and leaves each flag unchanged whose written value is 1.
- R7: A status read while control bit 5 is 1 returns the current flags, and bits 6 and 5 are 1 from the next edge on. A status read while control bit 5 is 0 has no effect on the flags.
- R8: A `brk_evt` pulse sets status bit 4. A `rx_full_evt` pulse sets bit 1. A `rx_rdy_evt` pulse sets bit 0. A hardware set wins over a software clear in the same cycle.
- R9: A read of any offset other than 0x00, 0x08 and 0x10 returns 0, and a write to such an offset changes no register. `bus_rdata` is 0 when `bus_rd` is low.
- R10: When a status read and a status write occur in the same cycle, only the write acts, and the read does not set the transmit flags again.
- R11: The outputs `flag_txend`, `flag_txempty`, `flag_brk`, `flag_rxfull` and `flag_rdy` equal status bits 6, 5, 4, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Combinational read data |
| brk_evt | input | 1 | Break-detected pulse from the receiver |
| rx_full_evt | input | 1 | Receive FIFO reached its trigger level |
| rx_rdy_evt | input | 1 | Receive data ready pulse |
| mode_val | output | DATA_W | Current mode register |
| ctrl_val | output | DATA_W | Current control register |
| tx_irq | output | 1 | Transmit interrupt request |
| flag_txend | output | 1 | Transmit-end flag |
| flag_txempty | output | 1 | Transmit-empty flag |
| flag_brk | output | 1 | Break flag |
| flag_rxfull | output | 1 | Receive-full flag |
| flag_rdy | output | 1 | Data-ready flag |

## Verification
On every cycle, the assertions check the masking of mode and control writes and the link between `tx_irq` and the written interrupt bit. They also check that transmit-end is set when transmit enable goes low, that status reads set the transmit flags again, that break pulses set their flag, that unmapped reads return zero, and that a write wins over a read of the status register in the same cycle. Only the bench scenarios show the following: the sequence of clear-by-zero writes across many flag patterns, that a read returns the flag values from before the read, that an ignored write to an unmapped offset leaves the registers intact, and that a hardware set wins over a software clear in the same cycle.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MODE = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   // Status flag bit positions (decoded by software)
   localparam int FLG_TEND = 6;
   localparam int FLG_TDE  = 5;
   localparam int FLG_BRK  = 4;
   localparam int FLG_RDF  = 1;
   localparam int FLG_DR   = 0;

   // Control bit positions
   localparam int TX_EN_BIT  = 5;
   localparam int TX_IRQ_BIT = 7;

endpackage

// File: rtl/ser_addr_dec.sv
module ser_addr_dec
   import ser_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int MODE_OFS = 'h00,
   parameter int CTRL_OFS = 'h08,
   parameter int STAT_OFS = 'h10
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   always_comb begin
      if (addr == MODE_A)      sel = SEL_MODE;
      else if (addr == CTRL_A) sel = SEL_CTRL;
      else if (addr == STAT_A) sel = SEL_STAT;
      else                     sel = SEL_NONE;
   end

endmodule

// File: rtl/ser_mask_reg.sv
module ser_mask_reg #(
   parameter int              W    = 8,
   parameter logic [W-1:0]    MASK = '1,
   parameter logic [W-1:0]    RST  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bit_q <= RST[i];
            else if (we) bit_q <= d[i];
         end
         assign q[i] = bit_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags #(
   parameter int           W        = 8,
   parameter logic [W-1:0] IMPL     = 8'h73,
   parameter logic [W-1:0] RST      = 8'h60
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_flag
      if (IMPL[i]) begin : g_store
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          f_q <= RST[i];
            else if (set_vec[i]) f_q <= 1'b1;   // hardware set wins
            else if (clr_vec[i]) f_q <= 1'b0;
         end
         assign q[i] = f_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/ser_rd_mux.sv
module ser_rd_mux
   import ser_ctrl_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         rd,
   input  reg_sel_e     sel,
   input  logic [W-1:0] mode_q,
   input  logic [W-1:0] ctrl_q,
   input  logic [W-1:0] stat_q,
   output logic [W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (sel)
            SEL_MODE: rdata = mode_q;
            SEL_CTRL: rdata = ctrl_q;
            SEL_STAT: rdata = stat_q;
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
   import ser_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int MODE_OFS  = 'h00,
   parameter int CTRL_OFS  = 'h08,
   parameter int STAT_OFS  = 'h10,
   parameter int MODE_MASK = 'h7B,
   parameter int CTRL_MASK = 'hFA,
   parameter int CTRL_RST  = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              brk_evt,
   input  logic              rx_full_evt,
   input  logic              rx_rdy_evt,
   output logic [DATA_W-1:0] mode_val,
   output logic [DATA_W-1:0] ctrl_val,
   output logic              tx_irq,
   output logic              flag_txend,
   output logic              flag_txempty,
   output logic              flag_brk,
   output logic              flag_rxfull,
   output logic              flag_rdy
);

   localparam logic [DATA_W-1:0] STAT_IMPL =
      DATA_W'((1 << FLG_TEND) | (1 << FLG_TDE) | (1 << FLG_BRK) |
              (1 << FLG_RDF)  | (1 << FLG_DR));
   localparam logic [DATA_W-1:0] STAT_RST =
      DATA_W'((1 << FLG_TEND) | (1 << FLG_TDE));
   localparam int ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (DATA_W < 8) begin : g_chk_dw
      $error("ser_ctrl_regs: DATA_W must be at least 8");
   end
   if (MODE_OFS >= ADDR_SPAN || CTRL_OFS >= ADDR_SPAN || STAT_OFS >= ADDR_SPAN) begin : g_chk_ofs
      $error("ser_ctrl_regs: register offset outside address range");
   end
   if (MODE_OFS == CTRL_OFS || MODE_OFS == STAT_OFS || CTRL_OFS == STAT_OFS) begin : g_chk_dup
      $error("ser_ctrl_regs: register offsets must differ");
   end
   if (((CTRL_MASK >> TX_EN_BIT) & 1) == 0 || ((CTRL_MASK >> TX_IRQ_BIT) & 1) == 0) begin : g_chk_cm
      $error("ser_ctrl_regs: control mask must keep enable and interrupt bits");
   end

   reg_sel_e          sel;
   logic              wr_mode, wr_ctrl, wr_stat, rd_stat, reload;
   logic [DATA_W-1:0] stat_q, set_vec, clr_vec;

   ser_addr_dec #(
      .ADDR_W   (ADDR_W),
      .MODE_OFS (MODE_OFS),
      .CTRL_OFS (CTRL_OFS),
      .STAT_OFS (STAT_OFS)
   ) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr_mode = bus_wr && (sel == SEL_MODE);
   assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
   assign wr_stat = bus_wr && (sel == SEL_STAT);
   assign rd_stat = bus_rd && (sel == SEL_STAT);

   ser_mask_reg #(
      .W    (DATA_W),
      .MASK (DATA_W'(MODE_MASK)),
      .RST  ('0)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_mode),
      .d     (bus_wdata),
      .q     (mode_val)
   );

   ser_mask_reg #(
      .W    (DATA_W),
      .MASK (DATA_W'(CTRL_MASK)),
      .RST  (DATA_W'(CTRL_RST))
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ctrl),
      .d     (bus_wdata),
      .q     (ctrl_val)
   );

   // A status read re-arms the transmit flags only when no write shares the cycle
   assign reload = rd_stat && !wr_stat && ctrl_val[TX_EN_BIT];

   always_comb begin
      set_vec           = '0;
      set_vec[FLG_TEND] = reload || (wr_ctrl && !bus_wdata[TX_EN_BIT]);
      set_vec[FLG_TDE]  = reload;
      set_vec[FLG_BRK]  = brk_evt;
      set_vec[FLG_RDF]  = rx_full_evt;
      set_vec[FLG_DR]   = rx_rdy_evt;
   end

   assign clr_vec = wr_stat ? ~bus_wdata : '0;

   ser_stat_flags #(
      .W    (DATA_W),
      .IMPL (STAT_IMPL),
      .RST  (STAT_RST)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .q       (stat_q)
   );

   ser_rd_mux #(
      .W (DATA_W)
   ) u_rmux (
      .rd     (bus_rd),
      .sel    (sel),
      .mode_q (mode_val),
      .ctrl_q (ctrl_val),
      .stat_q (stat_q),
      .rdata  (bus_rdata)
   );

   assign tx_irq       = ctrl_val[TX_IRQ_BIT];
   assign flag_txend   = stat_q[FLG_TEND];
   assign flag_txempty = stat_q[FLG_TDE];
   assign flag_brk     = stat_q[FLG_BRK];
   assign flag_rxfull  = stat_q[FLG_RDF];
   assign flag_rdy     = stat_q[FLG_DR];

endmodule

// File: rtl/ser_ctrl_regs_chk.sv
module ser_ctrl_regs_chk #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int MODE_OFS  = 'h00,
   parameter int CTRL_OFS  = 'h08,
   parameter int STAT_OFS  = 'h10,
   parameter int MODE_MASK = 'h7B,
   parameter int CTRL_MASK = 'hFA
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              brk_evt,
   input logic [DATA_W-1:0] mode_val,
   input logic [DATA_W-1:0] ctrl_val,
   input logic              tx_irq,
   input logic              flag_txend,
   input logic              flag_txempty,
   input logic              flag_brk
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [DATA_W-1:0] M_MODE = DATA_W'(MODE_MASK);
   localparam logic [DATA_W-1:0] M_CTRL = DATA_W'(CTRL_MASK);

   logic hit_mode_w, hit_ctrl_w, hit_stat_w, hit_stat_r, unmapped;
   assign hit_mode_w = bus_wr && bus_addr == A_MODE;
   assign hit_ctrl_w = bus_wr && bus_addr == A_CTRL;
   assign hit_stat_w = bus_wr && bus_addr == A_STAT;
   assign hit_stat_r = bus_rd && bus_addr == A_STAT;
   assign unmapped   = bus_addr != A_MODE && bus_addr != A_CTRL && bus_addr != A_STAT;

   p_mode_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mode_w |=> mode_val == ($past(bus_wdata) & M_MODE));

   p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl_w |=> ctrl_val == ($past(bus_wdata) & M_CTRL));

   p_txoff_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl_w && !bus_wdata[5]) |=> flag_txend);

   p_txirq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl_w |=> tx_irq == $past(bus_wdata[7]));

   p_read_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat_r && !bus_wr && ctrl_val[5]) |=> (flag_txend && flag_txempty));

   p_break_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> flag_brk);

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |-> bus_rdata == '0);

   p_wr_over_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat_r && hit_stat_w && !bus_wdata[5]) |=> !flag_txempty);

endmodule

bind ser_ctrl_regs ser_ctrl_regs_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .MODE_OFS  (MODE_OFS),
   .CTRL_OFS  (CTRL_OFS),
   .STAT_OFS  (STAT_OFS),
   .MODE_MASK (MODE_MASK),
   .CTRL_MASK (CTRL_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_rdata    (bus_rdata),
   .brk_evt      (brk_evt),
   .mode_val     (mode_val),
   .ctrl_val     (ctrl_val),
   .tx_irq       (tx_irq),
   .flag_txend   (flag_txend),
   .flag_txempty (flag_txempty),
   .flag_brk     (flag_brk)
);

// File: tb/ser_ctrl_regs_test.sv
module ser_ctrl_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       brk_evt = 1'b0, rx_full_evt = 1'b0, rx_rdy_evt = 1'b0;
   logic [7:0] mode_val, ctrl_val;
   logic       tx_irq, flag_txend, flag_txempty, flag_brk, flag_rxfull, flag_rdy;

   int checks = 0;
   int failures = 0;
   logic [7:0] rd_cap;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   ser_ctrl_regs uut (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
      .brk_evt (brk_evt), .rx_full_evt (rx_full_evt), .rx_rdy_evt (rx_rdy_evt),
      .mode_val (mode_val), .ctrl_val (ctrl_val), .tx_irq (tx_irq),
      .flag_txend (flag_txend), .flag_txempty (flag_txempty), .flag_brk (flag_brk),
      .flag_rxfull (flag_rxfull), .flag_rdy (flag_rdy)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   // One bus cycle; rd_cap holds the combinational read data before the edge
   task automatic cyc(input logic wr, input logic rd, input logic [5:0] a,
                      input logic [7:0] d, input logic brk, input logic rxf,
                      input logic rxr);
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      brk_evt = brk; rx_full_evt = rxf; rx_rdy_evt = rxr;
      #2 rd_cap = bus_rdata;
      @(posedge clk);
      #1;
      bus_wr = 0; bus_rd = 0; brk_evt = 0; rx_full_evt = 0; rx_rdy_evt = 0;
   endtask

   function automatic logic [7:0] flags_now();
      return {1'b0, flag_txend, flag_txempty, flag_brk, 2'b00, flag_rxfull, flag_rdy};
   endfunction

   // {req[3:0], pad[2:0], is_read, addr[7:0], wdata[7:0], expected[7:0]}
   localparam int NVEC = 20;
   localparam logic [31:0] VEC [NVEC] = '{
      {4'd1,  3'd0, 1'b1, 8'h00, 8'h00, 8'h00},  // R1 mode reset 0x00
      {4'd2,  3'd0, 1'b1, 8'h08, 8'h00, 8'h20},  // R2 control reset 0x20
      {4'd5,  3'd0, 1'b1, 8'h10, 8'h00, 8'h60},  // R5 status reset 0x60
      {4'd1,  3'd0, 1'b0, 8'h00, 8'hFF, 8'h00},
      {4'd1,  3'd0, 1'b1, 8'h00, 8'h00, 8'h7B},  // R1 mask 0x7B
      {4'd1,  3'd0, 1'b0, 8'h00, 8'h84, 8'h00},
      {4'd1,  3'd0, 1'b1, 8'h00, 8'h00, 8'h00},  // R1 bits 7,2 never stored
      {4'd2,  3'd0, 1'b0, 8'h08, 8'hFF, 8'h00},
      {4'd2,  3'd0, 1'b1, 8'h08, 8'h00, 8'hFA},  // R2 mask 0xFA
      {4'd6,  3'd0, 1'b0, 8'h10, 8'h00, 8'h00},
      {4'd6,  3'd0, 1'b1, 8'h10, 8'h00, 8'h00},  // R6 zeros clear all; R7 read shows pre-read
      {4'd7,  3'd0, 1'b1, 8'h10, 8'h00, 8'h60},  // R7 re-armed by previous read
      {4'd6,  3'd0, 1'b0, 8'h10, 8'hDF, 8'h00},
      {4'd6,  3'd0, 1'b0, 8'h08, 8'h5A, 8'h00},  // ctrl=0x5A, TX enable off
      {4'd6,  3'd0, 1'b1, 8'h10, 8'h00, 8'h40},  // R6 only bit 5 cleared
      {4'd6,  3'd0, 1'b0, 8'h10, 8'h00, 8'h00},
      {4'd3,  3'd0, 1'b0, 8'h08, 8'h00, 8'h00},
      {4'd3,  3'd0, 1'b1, 8'h10, 8'h00, 8'h40},  // R3 end flag set by enable-off write
      {4'd7,  3'd0, 1'b1, 8'h10, 8'h00, 8'h40},  // R7 no re-arm while disabled
      {4'd9,  3'd0, 1'b1, 8'h04, 8'h00, 8'h00}   // R9 unmapped read
   };

   initial begin : watchdog
      #(8 * 100000);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // Reset state (R4, R5, R9, R11)
      check("R4 tx_irq reset", {7'd0, tx_irq}, 8'h00);
      check("R11 flags reset", flags_now(), 8'h60);
      check("R9 rdata idle", bus_rdata, 8'h00);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] v;
         v = VEC[i];
         cyc(!v[24], v[24], v[21:16], v[15:8], 1'b0, 1'b0, 1'b0);
         if (v[24])
            check($sformatf("R%0d vector %0d", v[31:28], i), rd_cap, v[7:0]);
         if (i == 7) check("R4 tx_irq after 0xFF", {7'd0, tx_irq}, 8'h01);
         if (i == 13) check("R4 tx_irq after 0x5A", {7'd0, tx_irq}, 8'h00);
      end

      // R9: unmapped write is ignored (mode=0x00, ctrl=0x00 at this point)
      cyc(1, 0, 6'h04, 8'hFF, 0, 0, 0);
      cyc(0, 1, 6'h00, 8'h00, 0, 0, 0);
      check("R9 mode after unmapped write", rd_cap, 8'h00);
      cyc(0, 1, 6'h08, 8'h00, 0, 0, 0);
      check("R9 ctrl after unmapped write", rd_cap, 8'h00);

      // R8: break and receive events
      cyc(1, 0, 6'h10, 8'h00, 0, 0, 0);          // clear all -> 0x00
      cyc(0, 0, 6'h00, 8'h00, 1, 0, 0);
      check("R8 break flag", flags_now(), 8'h10);
      cyc(0, 0, 6'h00, 8'h00, 0, 1, 1);
      check("R11 rx flags", flags_now(), 8'h13);
      cyc(0, 1, 6'h10, 8'h00, 0, 0, 0);
      check("R5 status layout", rd_cap, 8'h13);
      cyc(1, 0, 6'h10, 8'hFE, 0, 0, 0);          // clear data-ready only
      check("R6 partial clear", flags_now(), 8'h12);
      cyc(1, 0, 6'h10, 8'h00, 1, 0, 0);          // clear all, break same cycle
      check("R8 set beats clear", flags_now(), 8'h10);

      // R10: simultaneous read and write with TX enabled
      cyc(1, 0, 6'h08, 8'h20, 0, 0, 0);          // ctrl=0x20
      cyc(1, 1, 6'h10, 8'h00, 0, 0, 0);
      check("R10 write wins over read", flags_now(), 8'h00);
      cyc(0, 1, 6'h10, 8'h00, 0, 0, 0);
      check("R7 read data pre-rearm", rd_cap, 8'h00);
      check("R7 re-armed flags", flags_now(), 8'h60);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule